// File: doc/BRIEF.md
# SPI FPGA Configuration Sequencer

This block acts as the SPI master that programs a target FPGA through its slave configuration port. A one-cycle `start` pulse, with a non-zero byte count on `bs_len`, launches a fixed run. The block reads the device identifier and rejects anything outside a two-entry whitelist. It reads the status once, then issues refresh, write-enable and erase commands. After that it polls the status word at a fixed interval until the erase has finished, and streams the bitstream in one framed burst write. It ends the run with a write disable and a final status read that must show the done flag.

The bitstream comes from upstream as bytes on a valid/ready handshake. If the upstream source pauses, the serial clock stops at its idle level until the next byte arrives. The run ends with a single-cycle `done_ok` or `err` pulse. `err_code` tells the four failure causes apart. The serial clock is divided down from the system clock. The poll interval is derived from a clock-frequency parameter.

Top module: `spi_cfg_seq`

## Requirements
- R1: Every command frame starts with `cs_n` falling and ends with `cs_n` rising. The frame is a sequence of bytes sent MSB first in SPI mode 0: `sclk` is low whenever `cs_n` is high, `mosi` only changes while `sclk` is low, and `miso` is sampled on the rising edge. Each frame is one opcode byte followed by stuffing bytes. Read frames are 8 bytes long and carry zero in every byte after the opcode. The response word is built from received bytes 4..7, with byte 4 as bits 7:0 and byte 7 as bits 31:24.
- R2: The first frame is read-ID (opcode 0x07). If the word differs from both 0xC2088080 and 0xC2048080, the run ends with `err_code` 2 and no further frame is sent.
- R3: After an accepted ID, the block sends these frames in order: read-status (0x09, 8 bytes), refresh (0x71), write enable (0x4A) and erase (0x70). The last three are 4 bytes each, with zero stuffing, and `cs_n` goes high between frames.
- R4: After erase, read-status frames are sent. The first comes at once. Each later one starts at least the poll interval (CLK_HZ/1000*POLL_MS cycles) after the previous one ended. Polling stops with success only when the word equals exactly 0x00010000.
- R5: If MAX_POLLS status reads in a row miss that value, the run ends with `err_code` 3 and no burst frame is sent.
- R6: The burst frame is one `cs_n` frame: 0x41, three 0xFF bytes, the `bs_len` bitstream bytes in arrival order, then four 0x00 bytes.
- R7: `bs_ready` is high only while the burst frame waits for its next bitstream byte. While `bs_valid` is low, `sclk` stays low and `cs_n` stays asserted. Exactly `bs_len` handshakes take place per run.
- R8: After the burst, the block sends write disable (0x4F, 4 bytes) and then a read-status frame. If bit mask 0x00004000 is set in that word, `done_ok` pulses. Otherwise the run ends with `err_code` 4.
- R9: A start with `bs_len` equal to zero gives an `err` pulse with `err_code` 1 on the next cycle. No frame is sent and `busy` stays low.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which `done_ok` or `err` pulses. Each pulse lasts one cycle, the two pulses never coincide, and `err_code` holds the cause (1 zero length, 2 bad ID, 3 erase timeout, 4 done missing) until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a run |
| bs_len | input | LEN_W | Bitstream length in bytes, sampled at start |
| bs_data | input | 8 | Bitstream byte |
| bs_valid | input | 1 | Bitstream byte present |
| bs_ready | output | 1 | Block takes the byte this cycle |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | Serial data to the target |
| cs_n | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data from the target |
| busy | output | 1 | Run in progress |
| done_ok | output | 1 | One-cycle pulse: configuration succeeded |
| err | output | 1 | One-cycle pulse: run aborted |
| err_code | output | 3 | Failure cause, held until the next start |

## Verification
The embedded properties assume that `start` is pulsed only while `busy` is low, and that `bs_data` is stable whenever `bs_valid` is high and no handshake has happened yet. The bench issues a start only after the previous run has signalled its end. It changes the source byte only after the handshake has been seen. It also holds `bs_valid` low for a varying number of cycles before each byte, so that the stall path is exercised while the assumptions still hold. The target model answers `miso` from its own bit counter, which advances on the rising edges of `sclk`. The SPI mode-0 timing therefore depends on the block keeping `mosi` steady across each rising edge.

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int POLL_MS   = 10,
  parameter int MAX_POLLS = 500,
  parameter int SCK_DIV   = 4,
  parameter int LEN_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] bs_len,
  input  logic [7:0]       bs_data,
  input  logic             bs_valid,
  output logic             bs_ready,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  input  logic             miso,
  output logic             busy,
  output logic             done_ok,
  output logic             err,
  output logic [2:0]       err_code
);
  localparam int POLL_CYC = CLK_HZ / 1000 * POLL_MS;
  localparam int PT_W = $clog2(POLL_CYC + 1);
  localparam int PC_W = $clog2(MAX_POLLS + 1);
  localparam int DV_W = $clog2(SCK_DIV + 1);
  localparam int IW   = LEN_W + 1;
  localparam logic [31:0] ID_A = 32'hC208_8080;
  localparam logic [31:0] ID_B = 32'hC204_8080;
  localparam logic [31:0] ST_ERASED = 32'h0001_0000;
  localparam logic [31:0] ST_DONE   = 32'h0000_4000;

  typedef enum logic [3:0] {
    S_IDLE, S_RDID, S_RDST, S_RFSH, S_WREN, S_ERASE,
    S_POLL, S_WAIT, S_BURST, S_WDIS, S_FINAL
  } ph_t;

  ph_t             ph;
  logic            cs_q, sck_q, shifting, ok_q, err_q;
  logic [7:0]      tx, rxb, opc, nxt_byte;
  logic [31:0]     word;
  logic [2:0]      bitc, code_q;
  logic [DV_W-1:0] div;
  logic [IW-1:0]   idx, flen;
  logic [LEN_W-1:0] len_q;
  logic [PT_W-1:0] tmr;
  logic [PC_W-1:0] polls;
  logic            is_read, in_frame, need_data, can_load, frame_end, tick;

  assign is_read   = ph inside {S_RDID, S_RDST, S_POLL, S_FINAL};
  assign in_frame  = !(ph inside {S_IDLE, S_WAIT});
  assign flen      = (ph == S_BURST) ? {1'b0, len_q} + IW'(8) : (is_read ? IW'(8) : IW'(4));
  assign need_data = (ph == S_BURST) && idx >= IW'(4) && idx < {1'b0, len_q} + IW'(4);
  assign can_load  = in_frame && !cs_q && !shifting && idx != flen;
  assign frame_end = in_frame && !cs_q && !shifting && idx == flen;
  assign tick      = div == DV_W'(SCK_DIV - 1);
  assign bs_ready  = can_load && need_data;

  always_comb begin
    case (ph)
      S_RDID:  opc = 8'h07;
      S_RFSH:  opc = 8'h71;
      S_WREN:  opc = 8'h4A;
      S_ERASE: opc = 8'h70;
      S_BURST: opc = 8'h41;
      S_WDIS:  opc = 8'h4F;
      default: opc = 8'h09;
    endcase
    if (idx == '0)                          nxt_byte = opc;
    else if (ph == S_BURST && idx < IW'(4)) nxt_byte = 8'hFF;
    else if (need_data)                     nxt_byte = bs_data;
    else                                    nxt_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE; cs_q <= 1'b1; sck_q <= 1'b0; shifting <= 1'b0;
      tx <= '0; rxb <= '0; word <= '0; bitc <= '0; div <= '0; idx <= '0;
      len_q <= '0; tmr <= '0; polls <= '0; ok_q <= 1'b0; err_q <= 1'b0; code_q <= '0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (shifting) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            rxb   <= {rxb[6:0], miso};
          end else begin
            sck_q <= 1'b0;
            tx    <= {tx[6:0], 1'b0};
            bitc  <= bitc + 1'b1;
            if (bitc == 3'd7) begin
              shifting <= 1'b0;
              if (idx > IW'(4)) word <= {rxb, word[31:8]};
            end
          end
        end
      end else if (can_load && (!need_data || bs_valid)) begin
        tx <= nxt_byte; shifting <= 1'b1; div <= '0; bitc <= '0; idx <= idx + 1'b1;
      end

      case (ph)
        S_IDLE:
          if (start) begin
            code_q <= '0;
            if (bs_len == '0) begin
              err_q <= 1'b1; code_q <= 3'd1;
            end else begin
              len_q <= bs_len; polls <= '0; ph <= S_RDID;
            end
          end
        S_WAIT:
          if (tmr == PT_W'(POLL_CYC - 1)) begin
            tmr <= '0; ph <= S_POLL;
          end else tmr <= tmr + 1'b1;
        default:
          if (cs_q) begin
            cs_q <= 1'b0; idx <= '0;
          end else if (frame_end) begin
            cs_q <= 1'b1;
            case (ph)
              S_RDID:
                if (word == ID_A || word == ID_B) ph <= S_RDST;
                else begin ph <= S_IDLE; err_q <= 1'b1; code_q <= 3'd2; end
              S_RDST:  ph <= S_RFSH;
              S_RFSH:  ph <= S_WREN;
              S_WREN:  ph <= S_ERASE;
              S_ERASE: ph <= S_POLL;
              S_POLL:
                if (word == ST_ERASED) ph <= S_BURST;
                else if (polls == PC_W'(MAX_POLLS - 1)) begin
                  ph <= S_IDLE; err_q <= 1'b1; code_q <= 3'd3;
                end else begin
                  polls <= polls + 1'b1; tmr <= '0; ph <= S_WAIT;
                end
              S_BURST: ph <= S_WDIS;
              S_WDIS:  ph <= S_FINAL;
              default: begin
                ph <= S_IDLE;
                if ((word & ST_DONE) != '0) ok_q <= 1'b1;
                else begin err_q <= 1'b1; code_q <= 3'd4; end
              end
            endcase
          end
      endcase
    end
  end

  assign sclk     = sck_q;
  assign mosi     = tx[7];
  assign cs_n     = cs_q;
  assign busy     = ph != S_IDLE;
  assign done_ok  = ok_q;
  assign err      = err_q;
  assign err_code = code_q;

  p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bs_ready |-> (busy && !cs_n && !sclk));
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_ready && !bs_valid) |=> (!sclk && !cs_n));
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bs_len == '0) |=> (err && err_code == 3'd1 && cs_n && !busy));
  p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && err));
  p_code_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code >= 3'd1 && err_code <= 3'd4));
  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_ok || err));
endmodule

// File: tb/spi_cfg_seq_tb_top.sv
module spi_cfg_seq_tb_top;
  localparam int CLK_HZ = 100_000, POLL_MS = 1, MAX_POLLS = 4, SCK_DIV = 2, LEN_W = 8;
  localparam int POLL_CYC = CLK_HZ / 1000 * POLL_MS;

  logic clk = 0, rst_n = 0, start = 0, bs_valid = 0, miso;
  logic [LEN_W-1:0] bs_len = '0;
  logic [7:0] bs_data = '0;
  logic bs_ready, sclk, mosi, cs_n, busy, done_ok, err;
  logic [2:0] err_code;

  always #5 clk = ~clk;

  spi_cfg_seq #(.CLK_HZ(CLK_HZ), .POLL_MS(POLL_MS), .MAX_POLLS(MAX_POLLS),
                .SCK_DIV(SCK_DIV), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bs_len(bs_len), .bs_data(bs_data),
    .bs_valid(bs_valid), .bs_ready(bs_ready), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .busy(busy), .done_ok(done_ok), .err(err), .err_code(err_code));

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  longint cyc = 0;
  always @(posedge clk) cyc++;

  // target model
  logic [7:0] sh;
  int bitc = 0, bytec = 0, nfr = 0, npoll = 0, clr_after = 0;
  logic [7:0] fop[32];
  int flen_a[32];
  longint fstart[32], fend[32];
  logic [7:0] bb[64];
  bit stuff_bad, clr_seen, wd_seen;
  logic [31:0] resp = 0, id_cur = 0, fin_cur = 0;

  always @(negedge cs_n) begin
    bitc = 0; bytec = 0; resp = 0;
    if (nfr < 32) fstart[nfr] = cyc;
  end
  always @(posedge sclk) if (!cs_n && nfr < 32) begin
    sh = {sh[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      if (bytec == 0) begin
        fop[nfr] = sh;
        if (sh == 8'h07) resp = id_cur;
        else if (sh == 8'h09)
          resp = wd_seen ? fin_cur : (clr_seen ? (npoll >= clr_after ? 32'h0001_0000 : 32'h0001_0010) : 32'h0);
      end else if (fop[nfr] != 8'h41 && sh != 8'h00) stuff_bad = 1;
      if (fop[nfr] == 8'h41 && bytec < 64) bb[bytec] = sh;
      bytec++;
    end
  end
  always @(posedge cs_n) if (nfr < 32 && rst_n) begin
    flen_a[nfr] = bytec; fend[nfr] = cyc;
    if (fop[nfr] == 8'h70) clr_seen = 1;
    if (fop[nfr] == 8'h4F) wd_seen = 1;
    if (fop[nfr] == 8'h09 && clr_seen && !wd_seen) npoll++;
    nfr++;
  end
  assign miso = (!cs_n && bytec >= 4 && bytec < 8) ? resp[(bytec - 4) * 8 + 7 - bitc] : 1'b0;

  int hs = 0;
  bit got_ok, got_err;
  logic [2:0] got_code;
  always @(posedge clk) begin
    if (bs_valid && bs_ready) hs++;
    if (done_ok) got_ok = 1;
    if (err) begin got_err = 1; got_code = err_code; end
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37 + seed * 11 + 8'h5A) ^ 8'hC3);
  endfunction

  bit stall_bad;
  task automatic source(input int len, input int gap, input int seed);
    for (int i = 0; i < len; i++) begin
      bs_valid = 0;
      for (int g = 0; g < (i + gap) % 3 * gap; g++) begin
        @(negedge clk);
        if (bs_ready && (sclk || cs_n)) stall_bad = 1;
      end
      bs_valid = 1; bs_data = pat(i, seed);
      while (!bs_ready) @(negedge clk);
      @(negedge clk);
      bs_valid = 0;
    end
  endtask

  task automatic run(input logic [31:0] id, input int ca, input logic [31:0] fin,
                     input int len, input int gap, input int seed, output bit timed_out);
    int t = 0;
    nfr = 0; npoll = 0; clr_seen = 0; wd_seen = 0; stuff_bad = 0; stall_bad = 0;
    hs = 0; got_ok = 0; got_err = 0; got_code = 0;
    id_cur = id; clr_after = ca; fin_cur = fin;
    @(negedge clk); bs_len = LEN_W'(len); start = 1;
    @(negedge clk); start = 0;
    check(busy == (len != 0), "R10 busy after start", busy, len != 0);
    fork
      source(len, gap, seed);
      while (!got_ok && !got_err && t < 40000) begin @(negedge clk); t++; end
    join_any
    while (!got_ok && !got_err && t < 40000) begin @(negedge clk); t++; end
    disable fork;
    bs_valid = 0;
    timed_out = t >= 40000;
    check(!timed_out, "watchdog run ended", t, 0);
    @(negedge clk);
    check(!busy && cs_n && !sclk, "R10 idle after end", {busy, cs_n, sclk}, 3'b010);
  endtask

  logic [7:0] eop[32];
  int elen[32];

  initial begin
    bit to;
    int ne;
    bit seq_ok, data_ok, space_ok;
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !busy && !done_ok && !err && !bs_ready, "R1 reset state",
          {cs_n, sclk, busy}, 3'b100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(32'hC2088080, 0, 32'h4000, 0, 0, 0, to);
    check(got_err && got_code == 1, "R9 zero length code", got_code, 1);
    check(nfr == 0, "R9 no frames", nfr, 0);

    run(32'hC2088081, 0, 32'h4000, 3, 0, 1, to);
    check(got_err && got_code == 2, "R2 bad id code", got_code, 2);
    check(nfr == 1 && fop[0] == 8'h07 && flen_a[0] == 8, "R2 only id frame", nfr, 1);
    check(hs == 0, "R7 no handshake on bad id", hs, 0);

    for (int idsel = 0; idsel < 2; idsel++)
      for (int len = 1; len <= 5; len++)
        for (int gap = 0; gap < 2; gap++) begin
          int ca = len % 3;
          run(idsel ? 32'hC2048080 : 32'hC2088080, ca, 32'hA5A5_4000, len, gap, len + gap, to);
          check(got_ok && !got_err, "R8 done flagged", got_code, 0);
          ne = 0;
          eop[ne] = 8'h07; elen[ne++] = 8;
          eop[ne] = 8'h09; elen[ne++] = 8;
          eop[ne] = 8'h71; elen[ne++] = 4;
          eop[ne] = 8'h4A; elen[ne++] = 4;
          eop[ne] = 8'h70; elen[ne++] = 4;
          for (int p = 0; p <= ca; p++) begin eop[ne] = 8'h09; elen[ne++] = 8; end
          eop[ne] = 8'h41; elen[ne++] = len + 8;
          eop[ne] = 8'h4F; elen[ne++] = 4;
          eop[ne] = 8'h09; elen[ne++] = 8;
          seq_ok = nfr == ne;
          for (int f = 0; f < ne && f < nfr; f++)
            if (fop[f] != eop[f] || flen_a[f] != elen[f]) seq_ok = 0;
          check(seq_ok, "R3 R8 frame order", nfr, ne);
          data_ok = bb[0] == 8'h41 && bb[1] == 8'hFF && bb[2] == 8'hFF && bb[3] == 8'hFF;
          for (int i = 0; i < len; i++) if (bb[4 + i] != pat(i, len + gap)) data_ok = 0;
          for (int i = 0; i < 4; i++) if (bb[4 + len + i] != 8'h00) data_ok = 0;
          check(data_ok, "R6 burst content", bb[4], pat(0, len + gap));
          check(!stuff_bad, "R1 zero stuffing", stuff_bad, 0);
          check(hs == len && !stall_bad, "R7 handshakes and stall", hs, len);
          space_ok = 1;
          for (int f = 6; f < 6 + ca; f++)
            if (fstart[f] - fend[f - 1] < POLL_CYC) space_ok = 0;
          check(space_ok, "R4 poll interval", ca, ca);
        end

    run(32'hC2048080, 1, 32'hFFFF_BFFF, 2, 1, 7, to);
    check(got_err && got_code == 4, "R8 done missing code", got_code, 4);
    check(!got_ok, "R10 no success pulse on failure", got_ok, 0);

    run(32'hC2088080, 1000, 32'h4000, 2, 0, 9, to);
    check(got_err && got_code == 3, "R5 timeout code", got_code, 3);
    check(npoll == MAX_POLLS && nfr == 5 + MAX_POLLS, "R5 poll count no burst", npoll, MAX_POLLS);
    check(hs == 0, "R5 no bitstream consumed", hs, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_900_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog global timeout actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule